// File: doc/BRIEF.md
# Four-Channel Prioritised DMA Controller

This block moves data between two addresses on behalf of software, without the processor touching each item. It holds four independent channels. Each channel has a programmed source address, destination address, unit count and control word, plus working copies of the addresses and count that advance as units move. A channel is started in one of four ways: at once when it is enabled, on a horizontal-blank pulse, on a vertical-blank pulse, or on a per-channel special request line.

Pending requests are arbitrated at every unit boundary, and the lowest-numbered enabled pending channel wins. A unit is 16 or 32 bits. It is moved as a read on a simple master port, followed by a write of the captured data. Each access is held until the slave acknowledges it.

At the end of a block the channel does one of two things. It switches itself off, or, in repeat mode, it reloads and waits for its next trigger. It can raise a one-cycle interrupt pulse when a block ends.

Top module: `quadDmaCtrl`

## Requirements
- R1: A written source or destination address has bit 0 forced to 0, so every bus address of a 16-bit unit is even.
- R2: A programmed count of 0 means 0x4000 units on channels 0, 1 and 2, and 0x10000 units on channel 3.
- R3: Each address steps after every unit according to its 2-bit mode. Code 0 increments, code 1 decrements, code 2 holds the address fixed, and code 3 increments (and, for the destination only, also reloads at the end of a block). The destination mode is control bits [1:0] and the source mode is bits [3:2].
- R4: Control bit 5 selects 32-bit units. Such units step by 4 bytes and drive bus addresses with bits [1:0] at 0. 16-bit units step by 2 bytes.
- R5: When control bit 15 (enable) is written from 0 to 1, the working source, destination and count are loaded from the programmed values. Address writes made later do not affect the block that is already armed.
- R6: Control bits [7:6] select the trigger: 0 immediate, 1 horizontal blank, 2 vertical blank, 3 special request. A pulse starts only enabled channels in the matching mode, and the special request is ignored on channel 0.
- R7: When several enabled channels are pending, the lowest-numbered one is served first.
- R8: When a block ends without repeat (control bit 4 clear), the control readback has bit 15 and bits [4:0] cleared and keeps its other bits.
- R9: When a block ends with repeat set, the count reloads, the destination reloads only in mode 3, and the channel stays enabled and makes no request until its next trigger.
- R10: With control bit 8 set, the channel's interrupt line pulses for exactly one cycle, in the cycle after the write acknowledge of the last unit of each block.
- R11: The sequential flag is low during the first unit of a block and high during its later units.
- R12: Each unit is a read request and then a write request of the captured read data. Each request and its address are held until acknowledged, and the bus returns idle after the write acknowledge.
- R13: After reset all channels are disabled, every control readback is 0, and no bus request or interrupt is driven.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regChan | input | 2 | Channel for register write and control readback |
| regSel | input | 2 | Register select: 0 source, 1 destination, 2 count, 3 control |
| regWdata | input | 32 | Write data (count and control use bits [15:0]) |
| ctrlRdata | output | 16 | Control word of the channel on regChan |
| hblankPulse | input | 1 | Horizontal-blank trigger pulse |
| vblankPulse | input | 1 | Vertical-blank trigger pulse |
| specialReq | input | 4 | Per-channel special trigger pulses |
| busReq | output | 1 | Master request valid |
| busWrite | output | 1 | 1 for a write request, 0 for a read request |
| busWide | output | 1 | 1 for a 32-bit unit, 0 for a 16-bit unit |
| busSeq | output | 1 | Sequential access flag |
| busAddr | output | 32 | Request address |
| busWdata | output | 32 | Write data (captured read data) |
| busRdata | input | 32 | Read data, sampled with the read acknowledge |
| busAck | input | 1 | Slave acknowledge of the current request |
| irqPulse | output | 4 | Per-channel end-of-block interrupt pulses |

## Verification
The handshake properties assume that the slave acknowledges only while a request is present. They also assume that the working addresses and the width of the channel being served are not disturbed while its unit is in flight. The bench's responder raises the acknowledge only when it sees a request, and it adds a programmable wait of up to two cycles so that held requests occur. Registers are rewritten only once the bus has gone quiet, with one exception: a 16-bit channel's control word is cleared mid-unit at the end of the long-count run, and that write changes neither its width nor its addresses.

// File: rtl/qdma_pkg.sv
package qdma_pkg;
  localparam int NUM_CH = 4;
  localparam int CH_W   = $clog2(NUM_CH);

  // register select codes
  localparam logic [1:0] SEL_SRC = 2'd0;
  localparam logic [1:0] SEL_DST = 2'd1;
  localparam logic [1:0] SEL_CNT = 2'd2;
  localparam logic [1:0] SEL_CTL = 2'd3;

  // control word fields
  localparam int B_DMODE = 0;
  localparam int B_SMODE = 2;
  localparam int B_RPT   = 4;
  localparam int B_WIDE  = 5;
  localparam int B_TRIG  = 6;
  localparam int B_IRQ   = 8;
  localparam int B_EN    = 15;

  // address step modes
  localparam logic [1:0] STEP_INC = 2'd0;
  localparam logic [1:0] STEP_DEC = 2'd1;
  localparam logic [1:0] STEP_FIX = 2'd2;
  localparam logic [1:0] STEP_RLD = 2'd3;

  // trigger modes
  localparam logic [1:0] TRIG_NOW = 2'd0;
  localparam logic [1:0] TRIG_HBL = 2'd1;
  localparam logic [1:0] TRIG_VBL = 2'd2;
  localparam logic [1:0] TRIG_SPC = 2'd3;

  // control -> datapath strobes
  typedef struct packed {
    logic            writePhase;
    logic            latchRead;
    logic            unitDone;
    logic [CH_W-1:0] chan;
  } qdmaStrobe_t;
endpackage

// File: rtl/qdmaDatapath.sv
module qdmaDatapath
  import qdma_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int CNT_W     = 16,
  parameter int SMALL_LOG = 14,
  parameter int BIG_CH    = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    regWe,
  input  logic [CH_W-1:0]         regChan,
  input  logic [1:0]              regSel,
  input  logic [ADDR_W-1:0]       regWdata,
  output logic [15:0]             ctrlRdata,
  input  logic [ADDR_W-1:0]       busRdata,
  input  qdmaStrobe_t             stb,
  output logic [NUM_CH-1:0]       chanEn,
  output logic [NUM_CH-1:0][1:0]  chanTrig,
  output logic [NUM_CH-1:0]       startNow,
  output logic [NUM_CH-1:0]       lastUnit,
  output logic [NUM_CH-1:0]       keepPend,
  output logic [ADDR_W-1:0]       busAddr,
  output logic                    busWide,
  output logic [ADDR_W-1:0]       busWdata,
  output logic                    busSeq,
  output logic [NUM_CH-1:0]       irqPulse
);
  localparam int WCNT_W = CNT_W + 1;
  localparam logic [WCNT_W-1:0] MAX_BIG   = WCNT_W'(1) << CNT_W;
  localparam logic [WCNT_W-1:0] MAX_SMALL = WCNT_W'(1) << SMALL_LOG;

  logic [ADDR_W-1:0] srcV  [NUM_CH];
  logic [ADDR_W-1:0] dstV  [NUM_CH];
  logic [15:0]       ctrlV [NUM_CH];
  logic [NUM_CH-1:0] wideV;
  logic [NUM_CH-1:0] midV;
  logic [ADDR_W-1:0] dataReg;

  function automatic logic [ADDR_W-1:0] nextAddr(input logic [ADDR_W-1:0] a,
                                                  input logic [1:0] mode,
                                                  input logic wide);
    logic [ADDR_W-1:0] stepV;
    stepV = wide ? ADDR_W'(4) : ADDR_W'(2);
    case (mode)
      STEP_DEC: return a - stepV;
      STEP_FIX: return a;
      default:  return a + stepV;
    endcase
  endfunction

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam logic [WCNT_W-1:0] FULL = (c == BIG_CH) ? MAX_BIG : MAX_SMALL;

    logic [ADDR_W-1:0] srcReg, dstReg, wSrc, wDst;
    logic [CNT_W-1:0]  cntReg;
    logic [WCNT_W-1:0] wCnt, progCnt;
    logic [15:0]       ctrlReg;
    logic              midBlk, irqR;
    logic              selHit, served, enRise, isWide;
    logic [1:0]        dMode, sMode;

    assign selHit  = regWe && (regChan == CH_W'(c));
    assign served  = stb.unitDone && (stb.chan == CH_W'(c));
    assign enRise  = selHit && (regSel == SEL_CTL) && regWdata[B_EN] && !ctrlReg[B_EN];
    assign progCnt = (cntReg == '0) ? FULL : {1'b0, cntReg};
    assign isWide  = ctrlReg[B_WIDE];
    assign dMode   = ctrlReg[B_DMODE +: 2];
    assign sMode   = ctrlReg[B_SMODE +: 2];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        srcReg  <= '0;
        dstReg  <= '0;
        wSrc    <= '0;
        wDst    <= '0;
        cntReg  <= '0;
        wCnt    <= '0;
        ctrlReg <= '0;
        midBlk  <= 1'b0;
        irqR    <= 1'b0;
      end else begin
        irqR <= served && lastUnit[c] && ctrlReg[B_IRQ];
        if (served) begin
          wSrc <= nextAddr(wSrc, sMode, isWide);
          if (lastUnit[c]) begin
            midBlk <= 1'b0;
            if (ctrlReg[B_RPT]) begin
              wCnt <= progCnt;
              wDst <= (dMode == STEP_RLD) ? dstReg : nextAddr(wDst, dMode, isWide);
            end else begin
              wDst                <= nextAddr(wDst, dMode, isWide);
              ctrlReg[B_EN]       <= 1'b0;
              ctrlReg[B_RPT:0]    <= '0;
            end
          end else begin
            wCnt   <= wCnt - WCNT_W'(1);
            wDst   <= nextAddr(wDst, dMode, isWide);
            midBlk <= 1'b1;
          end
        end
        if (selHit) begin
          case (regSel)
            SEL_SRC: srcReg <= {regWdata[ADDR_W-1:1], 1'b0};
            SEL_DST: dstReg <= {regWdata[ADDR_W-1:1], 1'b0};
            SEL_CNT: cntReg <= regWdata[CNT_W-1:0];
            default: begin
              ctrlReg <= regWdata[15:0];
              if (enRise) begin
                wSrc   <= srcReg;
                wDst   <= dstReg;
                wCnt   <= progCnt;
                midBlk <= 1'b0;
              end
            end
          endcase
        end
      end
    end

    assign lastUnit[c] = (wCnt == WCNT_W'(1));
    assign chanEn[c]   = ctrlReg[B_EN];
    assign chanTrig[c] = ctrlReg[B_TRIG +: 2];
    assign startNow[c] = enRise && (regWdata[B_TRIG +: 2] == TRIG_NOW);
    assign keepPend[c] = ctrlReg[B_RPT] && (ctrlReg[B_TRIG +: 2] == TRIG_NOW);
    assign irqPulse[c] = irqR;
    assign srcV[c]     = wSrc;
    assign dstV[c]     = wDst;
    assign ctrlV[c]    = ctrlReg;
    assign wideV[c]    = isWide;
    assign midV[c]     = midBlk;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              dataReg <= '0;
    else if (stb.latchRead) dataReg <= busRdata;
  end

  logic [ADDR_W-1:0] rawAddr;
  assign rawAddr   = stb.writePhase ? dstV[stb.chan] : srcV[stb.chan];
  assign busWide   = wideV[stb.chan];
  assign busAddr   = busWide ? {rawAddr[ADDR_W-1:2], 2'b00} : rawAddr;
  assign busSeq    = midV[stb.chan];
  assign busWdata  = dataReg;
  assign ctrlRdata = ctrlV[regChan];
endmodule

// File: rtl/qdmaControl.sv
module qdmaControl
  import qdma_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   hblankPulse,
  input  logic                   vblankPulse,
  input  logic [NUM_CH-1:0]      specialReq,
  input  logic                   busAck,
  input  logic [NUM_CH-1:0]      chanEn,
  input  logic [NUM_CH-1:0][1:0] chanTrig,
  input  logic [NUM_CH-1:0]      startNow,
  input  logic [NUM_CH-1:0]      lastUnit,
  input  logic [NUM_CH-1:0]      keepPend,
  output qdmaStrobe_t            stb,
  output logic                   busReq,
  output logic                   busWrite
);
  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} state_e;

  state_e            state;
  logic [CH_W-1:0]   chanR, pick;
  logic [NUM_CH-1:0] pend, pendNext, eligible;

  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      logic setEv, clrEv;
      setEv = startNow[c] ||
              (chanEn[c] && ((chanTrig[c] == TRIG_HBL && hblankPulse) ||
                             (chanTrig[c] == TRIG_VBL && vblankPulse) ||
                             (c != 0 && chanTrig[c] == TRIG_SPC && specialReq[c])));
      clrEv = stb.unitDone && (stb.chan == CH_W'(c)) && lastUnit[c] && !keepPend[c];
      pendNext[c] = ((pend[c] && !clrEv) || setEv) && (chanEn[c] || startNow[c]);
    end
  end

  assign eligible = pend & chanEn;

  always_comb begin
    pick = '0;
    for (int c = NUM_CH - 1; c >= 0; c--) begin
      if (eligible[c]) pick = CH_W'(c);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      chanR <= '0;
      pend  <= '0;
    end else begin
      pend <= pendNext;
      case (state)
        ST_IDLE: if (|eligible) begin
          chanR <= pick;
          state <= ST_RD;
        end
        ST_RD:   if (busAck) state <= ST_WR;
        default: if (busAck) state <= ST_IDLE;
      endcase
    end
  end

  assign busReq         = (state != ST_IDLE);
  assign busWrite       = (state == ST_WR);
  assign stb.writePhase = (state == ST_WR);
  assign stb.latchRead  = (state == ST_RD) && busAck;
  assign stb.unitDone   = (state == ST_WR) && busAck;
  assign stb.chan       = chanR;
endmodule

// File: rtl/quadDmaCtrl.sv
module quadDmaCtrl
  import qdma_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int CNT_W     = 16,
  parameter int SMALL_LOG = 14,
  parameter int BIG_CH    = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [1:0]        regChan,
  input  logic [1:0]        regSel,
  input  logic [ADDR_W-1:0] regWdata,
  output logic [15:0]       ctrlRdata,
  input  logic              hblankPulse,
  input  logic              vblankPulse,
  input  logic [3:0]        specialReq,
  output logic              busReq,
  output logic              busWrite,
  output logic              busWide,
  output logic              busSeq,
  output logic [ADDR_W-1:0] busAddr,
  output logic [ADDR_W-1:0] busWdata,
  input  logic [ADDR_W-1:0] busRdata,
  input  logic              busAck,
  output logic [3:0]        irqPulse
);
  qdmaStrobe_t             stb;
  logic [NUM_CH-1:0]       chanEn, startNow, lastUnit, keepPend;
  logic [NUM_CH-1:0][1:0]  chanTrig;

  qdmaControl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .hblankPulse (hblankPulse),
    .vblankPulse (vblankPulse),
    .specialReq  (specialReq),
    .busAck      (busAck),
    .chanEn      (chanEn),
    .chanTrig    (chanTrig),
    .startNow    (startNow),
    .lastUnit    (lastUnit),
    .keepPend    (keepPend),
    .stb         (stb),
    .busReq      (busReq),
    .busWrite    (busWrite)
  );

  qdmaDatapath #(
    .ADDR_W    (ADDR_W),
    .CNT_W     (CNT_W),
    .SMALL_LOG (SMALL_LOG),
    .BIG_CH    (BIG_CH)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .regWe     (regWe),
    .regChan   (regChan),
    .regSel    (regSel),
    .regWdata  (regWdata),
    .ctrlRdata (ctrlRdata),
    .busRdata  (busRdata),
    .stb       (stb),
    .chanEn    (chanEn),
    .chanTrig  (chanTrig),
    .startNow  (startNow),
    .lastUnit  (lastUnit),
    .keepPend  (keepPend),
    .busAddr   (busAddr),
    .busWide   (busWide),
    .busWdata  (busWdata),
    .busSeq    (busSeq),
    .irqPulse  (irqPulse)
  );
endmodule

// File: rtl/qdmaChecker.sv
module qdmaChecker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              busReq,
  input logic              busWrite,
  input logic              busWide,
  input logic              busSeq,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busAck,
  input logic [3:0]        irqPulse
);
  assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !busAck |=> busReq && $stable(busAddr) && $stable(busWrite));

  assert_read_then_write_R12: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !busWrite && busAck |=> busReq && busWrite);

  assert_write_release_R12: assert property (@(posedge clk) disable iff (!rstN)
    busReq && busWrite && busAck |=> !busReq);

  assert_wide_align_R4: assert property (@(posedge clk) disable iff (!rstN)
    busReq && busWide |-> busAddr[1:0] == 2'b00);

  assert_even_addr_R1: assert property (@(posedge clk) disable iff (!rstN)
    busReq |-> !busAddr[0]);

  assert_irq_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(irqPulse));

  assert_irq_after_ack_R10: assert property (@(posedge clk) disable iff (!rstN)
    (|irqPulse) |-> $past(busReq && busWrite && busAck));

  assert_seq_steady_R11: assert property (@(posedge clk) disable iff (!rstN)
    busReq && busWrite |-> $stable(busSeq));
endmodule

bind quadDmaCtrl qdmaChecker #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busReq   (busReq),
  .busWrite (busWrite),
  .busWide  (busWide),
  .busSeq   (busSeq),
  .busAddr  (busAddr),
  .busAck   (busAck),
  .irqPulse (irqPulse)
);

// File: tb/quadDmaCtrl_tb.sv
module quadDmaCtrl_tb;
  localparam int WDOG = 190000;
  localparam int VEC_N = 6;
  // sMode, dMode, wide, count, ackLat, srcStep, dstStep
  localparam int VTAB[VEC_N][7] = '{
    '{0, 0, 0, 3, 0,  2,  2},
    '{1, 2, 0, 3, 1, -2,  0},
    '{2, 1, 1, 3, 0,  0, -4},
    '{0, 3, 1, 2, 2,  4,  4},
    '{3, 0, 0, 1, 0,  2,  2},
    '{1, 1, 1, 3, 1, -4, -4}
  };

  logic        clk = 0, rstN = 0;
  logic        regWe = 0;
  logic [1:0]  regChan = 0, regSel = 0;
  logic [31:0] regWdata = 0;
  logic [15:0] ctrlRdata;
  logic        hblankPulse = 0, vblankPulse = 0;
  logic [3:0]  specialReq = 0;
  logic        busReq, busWrite, busWide, busSeq;
  logic [31:0] busAddr, busWdata;
  logic [31:0] busRdata = 0;
  logic        busAck = 0;
  logic [3:0]  irqPulse;

  quadDmaCtrl u_dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regChan(regChan), .regSel(regSel),
    .regWdata(regWdata), .ctrlRdata(ctrlRdata), .hblankPulse(hblankPulse),
    .vblankPulse(vblankPulse), .specialReq(specialReq), .busReq(busReq),
    .busWrite(busWrite), .busWide(busWide), .busSeq(busSeq), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .busAck(busAck), .irqPulse(irqPulse)
  );

  always #2 clk = ~clk;

  int checks = 0, errs = 0, cyc = 0;
  int ackLat = 0, waitCnt = 0;
  int rdN = 0, wrN = 0, wrTot = 0;
  int lastWrCyc = 0, lastIrqCyc = 0;
  int irqCnt[4] = '{0, 0, 0, 0};
  logic [31:0] rdAddr[64], wrAddr[64], wrData[64];
  logic        rdSeq[64];
  bit done = 0;

  function automatic logic [31:0] pattern(input logic [31:0] a);
    return a ^ 32'h5A5A_C3C3;
  endfunction

  function automatic logic [31:0] ctl(input int dm, input int sm, input int rpt, input int wide,
                                      input int trig, input int irq, input int en);
    return 32'(dm) | (32'(sm) << 2) | (32'(rpt) << 4) | (32'(wide) << 5) |
           (32'(trig) << 6) | (32'(irq) << 8) | (32'(en) << 15);
  endfunction

  // slave responder and monitor
  always @(negedge clk) begin
    if (busReq) begin
      if (waitCnt >= ackLat) begin busAck = 1; waitCnt = 0; end
      else begin busAck = 0; waitCnt++; end
    end else begin
      busAck = 0; waitCnt = 0;
    end
    busRdata = pattern(busAddr);
    if (busReq && busAck) begin
      if (!busWrite) begin
        if (rdN < 64) begin rdAddr[rdN] = busAddr; rdSeq[rdN] = busSeq; end
        rdN++;
      end else begin
        if (wrN < 64) begin wrAddr[wrN] = busAddr; wrData[wrN] = busWdata; end
        wrN++; wrTot++; lastWrCyc = cyc;
      end
    end
    for (int i = 0; i < 4; i++) if (irqPulse[i]) begin irqCnt[i]++; lastIrqCyc = cyc; end
    cyc++;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int ch, input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    regWe = 1; regChan = 2'(ch); regSel = sel; regWdata = d;
    @(negedge clk);
    regWe = 0;
  endtask

  task automatic rdCtl(input int ch, output logic [15:0] v);
    @(negedge clk);
    regChan = 2'(ch);
    #1 v = ctrlRdata;
  endtask

  task automatic settle(input int quiet);
    int q = 0;
    int guard = 0;
    while (q < quiet && guard < 100000) begin
      @(negedge clk);
      #1;
      q = busReq ? 0 : q + 1;
      guard++;
    end
  endtask

  task automatic clearLog();
    rdN = 0; wrN = 0;
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog: actual %0d expected %0d", WDOG, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errs);
      $finish;
    end
  end

  initial begin
    logic [15:0] rb;
    logic [31:0] e, cw;
    int i0;
    int base;

    // R13 reset state
    repeat (3) @(negedge clk);
    chk(busReq == 0, "R13 no request in reset", 32'(busReq), 0);
    rstN = 1;
    repeat (2) @(negedge clk);
    chk(busReq == 0 && irqPulse == 0, "R13 idle after reset", {irqPulse, 3'b0, busReq}, 0);
    for (int c = 0; c < 4; c++) begin
      rdCtl(c, rb);
      chk(rb == 0, "R13 control readback", 32'(rb), 0);
    end

    // table: R1 R3 R4 R8 R10 R11 R12 on channel 1, immediate trigger
    for (int v = 0; v < VEC_N; v++) begin
      clearLog();
      ackLat = VTAB[v][4];
      i0 = irqCnt[1];
      cw = ctl(VTAB[v][1], VTAB[v][0], 0, VTAB[v][2], 0, 1, 1);
      wr(1, 2'd0, 32'h0200_0013);
      wr(1, 2'd1, 32'h0300_0107);
      wr(1, 2'd2, 32'(VTAB[v][3]));
      wr(1, 2'd3, cw);
      settle(8);
      chk(wrN == VTAB[v][3], "R12 unit count", 32'(wrN), 32'(VTAB[v][3]));
      for (int k = 0; k < VTAB[v][3]; k++) begin
        e = 32'h0200_0012 + 32'(k * VTAB[v][5]);
        if (VTAB[v][2] != 0) e[1:0] = 2'b00;
        chk(rdAddr[k] == e, "R1/R3/R4 read address (R1 R3 R4)", rdAddr[k], e);
        e = 32'h0300_0106 + 32'(k * VTAB[v][6]);
        if (VTAB[v][2] != 0) e[1:0] = 2'b00;
        chk(wrAddr[k] == e, "R3 write address (R4)", wrAddr[k], e);
        chk(wrData[k] == pattern(rdAddr[k]), "R12 data copied", wrData[k], pattern(rdAddr[k]));
        chk(rdSeq[k] == (k != 0), "R11 sequential flag", 32'(rdSeq[k]), 32'(k != 0));
      end
      rdCtl(1, rb);
      chk(rb == (cw[15:0] & 16'h7FE0), "R8 readback after block", 32'(rb), 32'(cw[15:0] & 16'h7FE0));
      chk(irqCnt[1] == i0 + 1, "R10 one interrupt", 32'(irqCnt[1]), 32'(i0 + 1));
      chk(lastIrqCyc == lastWrCyc + 1, "R10 interrupt timing", 32'(lastIrqCyc), 32'(lastWrCyc + 1));
    end
    ackLat = 0;

    // R7 priority and R6 trigger matching
    clearLog();
    wr(2, 2'd0, 32'h0200_2000); wr(2, 2'd1, 32'h0320_0000); wr(2, 2'd2, 2);
    wr(2, 2'd3, ctl(0, 0, 0, 0, 1, 0, 1));
    wr(1, 2'd0, 32'h0200_1000); wr(1, 2'd1, 32'h0310_0000); wr(1, 2'd2, 2);
    wr(1, 2'd3, ctl(0, 0, 0, 0, 1, 0, 1));
    wr(3, 2'd0, 32'h0200_3000); wr(3, 2'd1, 32'h0330_0000); wr(3, 2'd2, 1);
    wr(3, 2'd3, ctl(0, 0, 0, 0, 2, 0, 1));
    settle(6);
    chk(wrN == 0, "R6 no start before pulse", 32'(wrN), 0);
    @(negedge clk) hblankPulse = 1;
    @(negedge clk) hblankPulse = 0;
    settle(8);
    chk(wrN == 4, "R6 only horizontal-blank channels ran", 32'(wrN), 4);
    chk(wrAddr[0] == 32'h0310_0000, "R7 lower channel first", wrAddr[0], 32'h0310_0000);
    chk(wrAddr[1] == 32'h0310_0002, "R7 lower channel block", wrAddr[1], 32'h0310_0002);
    chk(wrAddr[2] == 32'h0320_0000, "R7 higher channel after", wrAddr[2], 32'h0320_0000);
    clearLog();
    @(negedge clk) vblankPulse = 1;
    @(negedge clk) vblankPulse = 0;
    settle(8);
    chk(wrN == 1 && wrAddr[0] == 32'h0330_0000, "R6 vertical-blank channel", wrAddr[0], 32'h0330_0000);

    // R6 special ignored on channel 0, R5 latching on enable edge
    clearLog();
    wr(0, 2'd0, 32'h0200_6000); wr(0, 2'd1, 32'h0360_0000); wr(0, 2'd2, 1);
    wr(0, 2'd3, ctl(0, 0, 0, 0, 3, 0, 1));
    @(negedge clk) specialReq = 4'b0001;
    @(negedge clk) specialReq = 4'b0000;
    settle(20);
    chk(wrN == 0, "R6 special ignored on channel 0", 32'(wrN), 0);
    rdCtl(0, rb);
    chk(rb[15] == 1'b1, "R6 channel 0 still enabled", 32'(rb), 32'h8000);
    wr(0, 2'd3, 0);
    wr(2, 2'd0, 32'h0200_3000); wr(2, 2'd1, 32'h0340_0000); wr(2, 2'd2, 1);
    wr(2, 2'd3, ctl(0, 0, 0, 0, 3, 0, 1));
    wr(2, 2'd0, 32'h0200_4000);
    @(negedge clk) specialReq = 4'b0100;
    @(negedge clk) specialReq = 4'b0000;
    settle(8);
    chk(wrN == 1, "R6 special on channel 2", 32'(wrN), 1);
    chk(rdAddr[0] == 32'h0200_3000, "R5 address latched at enable", rdAddr[0], 32'h0200_3000);

    // R9 repeat with destination reload
    clearLog();
    i0 = irqCnt[1];
    wr(1, 2'd0, 32'h0200_5000); wr(1, 2'd1, 32'h0350_0000); wr(1, 2'd2, 2);
    wr(1, 2'd3, ctl(3, 0, 1, 0, 1, 1, 1));
    @(negedge clk) hblankPulse = 1;
    @(negedge clk) hblankPulse = 0;
    settle(8);
    chk(wrN == 2 && wrAddr[1] == 32'h0350_0002, "R9 first block", wrAddr[1], 32'h0350_0002);
    chk(irqCnt[1] == i0 + 1, "R10 repeat block interrupt", 32'(irqCnt[1]), 32'(i0 + 1));
    chk(lastIrqCyc == lastWrCyc + 1, "R10 repeat interrupt timing", 32'(lastIrqCyc), 32'(lastWrCyc + 1));
    rdCtl(1, rb);
    chk(rb[15] == 1'b1, "R9 stays enabled", 32'(rb), 32'h8000);
    clearLog();
    settle(12);
    chk(wrN == 0, "R9 waits for trigger", 32'(wrN), 0);
    @(negedge clk) hblankPulse = 1;
    @(negedge clk) hblankPulse = 0;
    settle(8);
    chk(wrN == 2, "R9 second block count reloaded", 32'(wrN), 2);
    chk(wrAddr[0] == 32'h0350_0000, "R9 destination reloaded", wrAddr[0], 32'h0350_0000);
    chk(rdAddr[0] == 32'h0200_5004, "R9 source continues", rdAddr[0], 32'h0200_5004);
    chk(rdSeq[0] == 1'b0 && rdSeq[1] == 1'b1, "R11 sequential per block", {rdSeq[0], rdSeq[1]}, 32'h1);
    wr(1, 2'd3, 0);

    // R2 zero count, channel 0 then channel 3
    base = wrTot;
    i0 = irqCnt[0];
    wr(0, 2'd0, 32'h0200_0000); wr(0, 2'd1, 32'h0300_0000); wr(0, 2'd2, 0);
    wr(0, 2'd3, ctl(0, 0, 0, 0, 0, 1, 1));
    while (irqCnt[0] == i0) @(negedge clk);
    settle(4);
    chk(wrTot - base == 32'h4000, "R2 channel 0 zero count", 32'(wrTot - base), 32'h4000);
    base = wrTot;
    i0 = irqCnt[3];
    wr(3, 2'd0, 32'h0200_0000); wr(3, 2'd1, 32'h0300_0000); wr(3, 2'd2, 0);
    wr(3, 2'd3, ctl(0, 0, 0, 0, 0, 1, 1));
    while (wrTot - base < 32'h4001) @(negedge clk);
    rdCtl(3, rb);
    chk(rb[15] == 1'b1 && irqCnt[3] == i0, "R2 channel 3 runs past 0x4000", 32'(rb), 32'h8000);
    wr(3, 2'd3, 0);
    settle(6);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end
endmodule